// File: doc/BRIEF.md
# Payload-gated doorbell acknowledge agent

This block sits on the answering side of a two-sided command mailbox. After reset it polls the mailbox's incoming flag word through a read port. A command counts as pending when bit 0 of that flag is set. The block does not answer a pending command until a separate data-plane signal, `payload_complete`, reports that the bulk transfer belonging to the command has finished. In this way the control handshake is tied to the completion of the data transfer.

Once both conditions hold, the block reads the incoming command word. It copies that word unchanged into the outgoing command register and then writes the acknowledge value 0x2 into the outgoing flag register. Both writes go through a write port. It then raises `done`, advances its acknowledge counter and issues no further requests until the next reset.

The read port is request/response and has no ready signal. The block pulses `rd_en` for one cycle and keeps at most one read outstanding. It waits any number of cycles for `rd_valid` and takes `rd_data` only in a cycle in which `rd_valid` is high. The write port is fire-and-forget: the mailbox must accept a write in the cycle in which `wr_en` is high.

Top module: `mbx_doorbell_ack`

## Requirements
- R1: During and straight after reset, `done` is 0, `ack_count` is 0 and `wr_en` is 0.
- R2: The block polls by reading address 0x20. The command is pending only when bit 0 (0x1) of the returned word is set; the other flag bits are ignored.
- R3: No write is issued while `payload_complete` has never been high since reset, however long the doorbell stays raised.
- R4: The first reply write happens strictly later than the first clock cycle in which `payload_complete` is sampled high.
- R5: The first reply write goes to address 0x10 and carries the word read from address 0x00, unchanged.
- R6: The cycle after the command write, the block writes 0x2 to address 0x30. Each acknowledge is exactly these two writes.
- R7: `ack_count` rises by exactly one per completed acknowledge and reads 1 after a single exchange; `done` is high from the cycle after the flag write.
- R8: Once `done` is high, it stays high and no further read or write is issued until reset.
- R9: A read and a write are never requested in the same cycle, at most one read is outstanding, and `rd_data` is taken only while `rd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | output | 1 | Read request pulse |
| rd_addr | output | ADDR_W (8) | Read address |
| rd_data | input | DATA_W (32) | Read response data |
| rd_valid | input | 1 | Read response strobe, one cycle or more after the request |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | ADDR_W (8) | Write address |
| wr_data | output | DATA_W (32) | Write data |
| payload_complete | input | 1 | Data-plane transfer finished |
| done | output | 1 | Acknowledge sent; the block has stopped |
| ack_count | output | CNT_W (8) | Number of completed acknowledges |

## Verification
The bench holds the doorbell up for a long stretch with `payload_complete` low. A design that forgot the gate would write early, and the bench would see the write. It also sets flag bits other than bit 0 while the payload is complete. A design that treated any nonzero flag as pending would then answer. The mailbox model drives all ones on `rd_data` whenever `rd_valid` is low, so a design that sampled data without the strobe would see a false doorbell or copy a corrupt command. Other runs raise the payload before the doorbell or after it and use differing command words. In each case the bench compares the cycle of the first write with the cycle in which the payload first rose, checks the address and data of both writes, and confirms that nothing follows `done`.

// File: rtl/mbx_ack_pkg.sv
package mbx_ack_pkg;

  typedef enum logic [2:0] {
    S_POLL,
    S_FLAG_WAIT,
    S_CMD_REQ,
    S_CMD_WAIT,
    S_WR_CMD,
    S_WR_FLAG,
    S_STOP
  } ack_state_e;

endpackage

// File: rtl/mbx_ack_seq.sv
module mbx_ack_seq
  import mbx_ack_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] IN_CMD_ADDR   = 8'h00,
  parameter logic [ADDR_W-1:0] OUT_CMD_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] IN_FLAG_ADDR  = 8'h20,
  parameter logic [ADDR_W-1:0] OUT_FLAG_ADDR = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  input  logic              pending,
  input  logic              payload_ok,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              sel_flag,
  output logic              cap_en,
  output logic              ack_pulse,
  output logic              stopped
);

  ack_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= S_POLL;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d   = state_q;
    rd_req    = 1'b0;
    rd_addr   = IN_FLAG_ADDR;
    wr_req    = 1'b0;
    wr_addr   = OUT_CMD_ADDR;
    sel_flag  = 1'b0;
    cap_en    = 1'b0;
    ack_pulse = 1'b0;
    unique case (state_q)
      S_POLL: begin
        rd_req  = 1'b1;
        rd_addr = IN_FLAG_ADDR;
        state_d = S_FLAG_WAIT;
      end
      S_FLAG_WAIT: begin
        if (rsp_valid) begin
          if (pending && payload_ok) state_d = S_CMD_REQ;
          else                       state_d = S_POLL;
        end
      end
      S_CMD_REQ: begin
        rd_req  = 1'b1;
        rd_addr = IN_CMD_ADDR;
        state_d = S_CMD_WAIT;
      end
      S_CMD_WAIT: begin
        if (rsp_valid) begin
          cap_en  = 1'b1;
          state_d = S_WR_CMD;
        end
      end
      S_WR_CMD: begin
        wr_req  = 1'b1;
        wr_addr = OUT_CMD_ADDR;
        state_d = S_WR_FLAG;
      end
      S_WR_FLAG: begin
        wr_req    = 1'b1;
        wr_addr   = OUT_FLAG_ADDR;
        sel_flag  = 1'b1;
        ack_pulse = 1'b1;
        state_d   = S_STOP;
      end
      S_STOP: state_d = S_STOP;
      default: state_d = S_POLL;
    endcase
  end

  assign stopped = (state_q == S_STOP);

  // R9: reads and writes are exclusive
  a_r9_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));
  // R9: no back-to-back read requests
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  // R6: flag write directly follows command write
  a_r6_flag_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_addr == OUT_CMD_ADDR) |=> (wr_req && wr_addr == OUT_FLAG_ADDR));
  // R8: once stopped, silent forever
  a_r8_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> (stopped && !rd_req && !wr_req));

endmodule

// File: rtl/mbx_ack_cmdreg.sv
module mbx_ack_cmdreg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (!rst_n)      dout <= '0;
    else if (cap_en) dout <= din;
  end

endmodule

// File: rtl/mbx_ack_counter.sv
module mbx_ack_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                       count <= '0;
    else if (inc && count != MAX_CNT) count <= count + 1'b1;
  end

  // R7: counter moves by one step at most
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == $past(count) + 1'b1));

endmodule

// File: rtl/mbx_doorbell_ack.sv
module mbx_doorbell_ack #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter logic [ADDR_W-1:0] IN_CMD_ADDR   = 8'h00,
  parameter logic [ADDR_W-1:0] OUT_CMD_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] IN_FLAG_ADDR  = 8'h20,
  parameter logic [ADDR_W-1:0] OUT_FLAG_ADDR = 8'h30,
  parameter logic [DATA_W-1:0] PEND_MASK     = 32'h0000_0001,
  parameter logic [DATA_W-1:0] ACK_VALUE     = 32'h0000_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_valid,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              payload_complete,
  output logic              done,
  output logic [CNT_W-1:0]  ack_count
);

  logic              pending;
  logic              sel_flag;
  logic              cap_en;
  logic              ack_pulse;
  logic [DATA_W-1:0] cmd_q;

  assign pending = |(rd_data & PEND_MASK);

  mbx_ack_seq #(
    .ADDR_W       (ADDR_W),
    .IN_CMD_ADDR  (IN_CMD_ADDR),
    .OUT_CMD_ADDR (OUT_CMD_ADDR),
    .IN_FLAG_ADDR (IN_FLAG_ADDR),
    .OUT_FLAG_ADDR(OUT_FLAG_ADDR)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (rd_valid),
    .pending   (pending),
    .payload_ok(payload_complete),
    .rd_req    (rd_en),
    .rd_addr   (rd_addr),
    .wr_req    (wr_en),
    .wr_addr   (wr_addr),
    .sel_flag  (sel_flag),
    .cap_en    (cap_en),
    .ack_pulse (ack_pulse),
    .stopped   (done)
  );

  mbx_ack_cmdreg #(.DATA_W(DATA_W)) u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_en(cap_en),
    .din   (rd_data),
    .dout  (cmd_q)
  );

  assign wr_data = sel_flag ? ACK_VALUE : cmd_q;

  mbx_ack_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (ack_pulse),
    .count(ack_count)
  );

  // Checker state: payload seen high at some earlier edge since reset
  logic pay_seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                pay_seen_q <= 1'b0;
    else if (payload_complete) pay_seen_q <= 1'b1;
  end

  // R3/R4: any write needs a payload rise at a strictly earlier edge
  a_r4_wr_after_payload: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> pay_seen_q);
  // R7: done rises together with a counter step
  a_r7_done_counts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (ack_count != $past(ack_count)));

endmodule

// File: tb/sim_mbx_doorbell_ack.sv
`timescale 1ns/1ps
module sim_mbx_doorbell_ack;

  logic        clk;
  logic        rst_n;
  logic        rd_en;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic        payload_complete;
  logic        done;
  logic [7:0]  ack_count;

  int total = 0;
  int bad   = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  mbx_doorbell_ack u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .payload_complete(payload_complete),
    .done(done), .ack_count(ack_count)
  );

  // Mailbox model: one-cycle read latency, all ones when not valid
  logic [31:0] host_cmd, host_flag;
  logic [31:0] reply_cmd, reply_flag;
  logic        rsp_v;
  logic [31:0] rsp_d;
  logic        mon_clr;

  always_ff @(posedge clk) begin
    rsp_v <= rd_en;
    case (rd_addr)
      8'h00:   rsp_d <= host_cmd;
      8'h10:   rsp_d <= reply_cmd;
      8'h20:   rsp_d <= host_flag;
      8'h30:   rsp_d <= reply_flag;
      default: rsp_d <= 32'h0;
    endcase
  end
  assign rd_valid = rsp_v;
  assign rd_data  = rsp_v ? rsp_d : 32'hFFFF_FFFF;

  // Monitor
  int          cyc;
  int          nwr;
  int          overlap;
  int          after_done;
  int          rise_cyc;
  int          first_wr_cyc;
  logic        pay_seen;
  logic [7:0]  wa0, wa1;
  logic [31:0] wd0, wd1;

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (mon_clr) begin
      nwr <= 0; overlap <= 0; after_done <= 0; pay_seen <= 1'b0;
      rise_cyc <= -1; first_wr_cyc <= -1;
      reply_cmd <= 32'h0; reply_flag <= 32'h0;
    end else begin
      if (payload_complete && !pay_seen) begin
        pay_seen <= 1'b1;
        rise_cyc <= cyc;
      end
      if (rd_en && wr_en) overlap <= overlap + 1;
      if (done && (rd_en || wr_en)) after_done <= after_done + 1;
      if (wr_en) begin
        nwr <= nwr + 1;
        if (nwr == 0) begin wa0 <= wr_addr; wd0 <= wr_data; first_wr_cyc <= cyc; end
        if (nwr == 1) begin wa1 <= wr_addr; wd1 <= wr_data; end
        if (wr_addr == 8'h10) reply_cmd  <= wr_data;
        if (wr_addr == 8'h30) reply_flag <= wr_data;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mon_clr = 1'b1;
    payload_complete = 1'b0; host_cmd = 32'h0; host_flag = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; mon_clr = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && !done; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // R1: reset state
  task automatic t_reset();
    do_reset();
    chk("R1 done", {31'b0, done}, 32'h0);
    chk("R1 ack_count", {24'b0, ack_count}, 32'h0);
    chk("R1 wr_en", {31'b0, wr_en}, 32'h0);
  endtask

  // R3: doorbell up for a long time, no payload
  task automatic t_no_payload();
    do_reset();
    host_cmd = 32'h1234_5678; host_flag = 32'h1;
    repeat (60) @(negedge clk);
    chk("R3 writes without payload", nwr, 0);
    chk("R3 done without payload", {31'b0, done}, 32'h0);
    chk("R9 overlap", overlap, 0);
  endtask

  // R2: other flag bits ignored; R9: idle all-ones data not taken as pending
  task automatic t_no_pending();
    do_reset();
    host_cmd = 32'hCAFE_0001; host_flag = 32'hFFFF_FFFE;
    payload_complete = 1'b1;
    repeat (60) @(negedge clk);
    chk("R2 writes without pending bit", nwr, 0);
    chk("R2 ack_count without pending", {24'b0, ack_count}, 32'h0);
  endtask

  task automatic check_exchange(input logic [31:0] cmd);
    chk("R5 first write addr", {24'b0, wa0}, 32'h10);
    chk("R5 first write data", wd0, cmd);
    chk("R6 second write addr", {24'b0, wa1}, 32'h30);
    chk("R6 second write data", wd1, 32'h2);
    chk("R6 write count", nwr, 2);
    chk("R4 first write after rise", {31'b0, (first_wr_cyc > rise_cyc) && (rise_cyc >= 0)}, 32'h1);
    chk("R7 ack_count", {24'b0, ack_count}, 32'h1);
    chk("R7 done", {31'b0, done}, 32'h1);
    chk("R5 reply register", reply_cmd, cmd);
    repeat (20) @(negedge clk);
    chk("R8 silent after done", after_done, 0);
    chk("R8 done held", {31'b0, done}, 32'h1);
    chk("R9 overlap", overlap, 0);
  endtask

  // Doorbell first, payload later
  task automatic t_doorbell_first(input logic [31:0] cmd);
    do_reset();
    host_cmd = cmd; host_flag = 32'h1;
    repeat (40) @(negedge clk);
    chk("R3 no write before payload", nwr, 0);
    payload_complete = 1'b1;
    wait_done(200);
    check_exchange(cmd);
  endtask

  // Payload first, doorbell later, with extra flag bits set
  task automatic t_payload_first(input logic [31:0] cmd);
    do_reset();
    payload_complete = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 no write before doorbell", nwr, 0);
    host_cmd = cmd; host_flag = 32'h0000_0F05;
    wait_done(200);
    check_exchange(cmd);
  endtask

  initial begin
    rst_n = 1'b0; mon_clr = 1'b1; payload_complete = 1'b0;
    host_cmd = 32'h0; host_flag = 32'h0;
    cyc = 0;
    t_reset();
    t_no_payload();
    t_no_pending();
    t_doorbell_first(32'h5ABB_A5AB);
    t_doorbell_first(32'hFFFF_FFFF);
    t_payload_first(32'h0000_0000);
    t_payload_first(32'h8001_7FFE);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule